// File: doc/BRIEF.md
# Strap-Latched CPU-to-PCI Clock Ratio Divider

This block produces a PCI-rate clock from the CPU-rate clock by dividing it by 2, 3 or 4. The ratio is looked up from a 4-bit frequency code. That code comes from one of two places. It can come from four strap inputs that are captured while power-on reset is held. It can also come from a 4-bit software code. A select pin picks between the two. The captured straps are also returned, bit-inverted, on a readback port so that a register file can expose them.

The divided clock always rises on a rising CPU edge and stays synchronous to it. A divide by 3 still gives an exact 50% duty cycle: the output falls on a falling CPU edge, half-way through the middle CPU cycle. A new code is adopted only on the rising edge that begins a new output period. A ratio change therefore never produces a shortened or stretched pulse. All pins are plain level controls. There is no stream interface and no handshake.

Top module: `clk_ratio_div`

## Requirements
- R1: While por_n_i is low, the strap latch loads strap_i on every rising clock edge. After release it keeps the value loaded at the last edge before release, and later strap_i changes have no effect until the next reset.
- R2: strap_rb_o is the bitwise inverse of the latched straps.
- R3: With sw_sel_i = 0 the requested code is the latched strap value. With sw_sel_i = 1 it is sw_code_i.
- R4: Codes 4'b1111, 4'b1110, 4'b1101, 4'b0111, 4'b0110 and 4'b0101 give an output period of 2 CPU cycles.
- R5: Codes 4'b1100, 4'b1011, 4'b1010, 4'b1001, 4'b1000, 4'b0100, 4'b0011 and 4'b0010 give an output period of 3 CPU cycles.
- R6: Codes 4'b0001 and 4'b0000 give an output period of 4 CPU cycles.
- R7: Each output period of N CPU cycles starts with a rise on a rising CPU edge. The output stays high for exactly N half-cycles and is low for the other N half-cycles. For N = 3, it falls on the falling CPU edge of the second cycle.
- R8: code_o shows the code in effect. A new requested code is adopted only on the rising edge that starts a new period. A change made earlier in the period leaves code_o and the output unchanged until that edge.
- R9: While por_n_i is low, div_clk_o is 0 and code_o is 4'b1111. The first rising edge after release starts a period using the code requested at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cpu_i | input | 1 | CPU-rate clock |
| por_n_i | input | 1 | Active-low power-on reset, asynchronous assert |
| strap_i | input | 4 | Frequency-select straps, captured during reset |
| sw_code_i | input | 4 | Software frequency code |
| sw_sel_i | input | 1 | 0: strap code, 1: software code |
| div_clk_o | output | 1 | Divided clock |
| code_o | output | 4 | Code currently in effect |
| strap_rb_o | output | 4 | Inverted latched straps for readback |

## Verification
The assertions assume three things about the inputs. The CPU clock runs while reset is held, so the straps are captured before release. Reset is released on a clean clock boundary. The software code and select change only away from rising clock edges. The stimulus meets all three. It drives every input two nanoseconds after a rising edge and holds reset for several clocks. It changes codes both right at a period start and in the middle of a period, which exercises the adoption rule. Outputs are sampled in both halves of every CPU cycle, so the duty cycle is observed at half-cycle resolution.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int CODE_W  = 4;
  localparam int RATIO_W = 3;
  typedef logic [CODE_W-1:0]  fcode_t;
  typedef logic [RATIO_W-1:0] ratio_t;
  localparam fcode_t RESET_CODE = '1;

  // frequency code to CPU cycles per output period
  function automatic ratio_t ratio_of(input fcode_t c);
    ratio_t r;
    case (c)
      4'hF, 4'hE, 4'hD, 4'h7, 4'h6, 4'h5: r = RATIO_W'(2);
      4'h1, 4'h0:                         r = RATIO_W'(4);
      default:                            r = RATIO_W'(3);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/strap_latch.sv
`timescale 1ns/1ps
module strap_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] strap_i,
  output logic [W-1:0] strap_q
);
  // follows the pins while reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_i;
  end

  // R1
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));
endmodule

// File: rtl/code_source.sv
`timescale 1ns/1ps
module code_source #(
  parameter int W = 4
) (
  input  logic         sel_sw,
  input  logic [W-1:0] strap_q,
  input  logic [W-1:0] sw_code,
  output logic [W-1:0] req_code,
  output logic [W-1:0] strap_rb
);
  always_comb begin
    req_code = sel_sw ? sw_code : strap_q;
    strap_rb = ~strap_q;
  end
endmodule

// File: rtl/ratio_divider.sv
`timescale 1ns/1ps
module ratio_divider
  import clkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  fcode_t req_code,
  output fcode_t code_o,
  output logic   div_clk_o
);
  fcode_t code_q;
  ratio_t cnt_q;
  ratio_t ratio_cur;
  ratio_t cnt_nxt;
  logic   period_end;
  logic   odd;
  logic   hi_p;
  logic   hi_n;
  logic [RATIO_W:0] half_pos;

  always_comb begin
    ratio_cur  = ratio_of(code_q);
    period_end = (cnt_q == ratio_cur - RATIO_W'(1));
    cnt_nxt    = cnt_q + RATIO_W'(1);
    half_pos   = {cnt_nxt, 1'b1};
    odd        = ratio_cur[0];
  end

  // rising-edge phase: count, adopt code at period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RESET_CODE;
      cnt_q  <= RATIO_W'(1);
      hi_p   <= 1'b0;
    end else if (period_end) begin
      code_q <= req_code;
      cnt_q  <= '0;
      hi_p   <= 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
      hi_p   <= (half_pos < {1'b0, ratio_cur});
    end
  end

  // falling-edge retime extends odd ratios by half a cycle
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hi_n <= 1'b0;
    else        hi_n <= hi_p;
  end

  assign div_clk_o = hi_p | (odd & hi_n);
  assign code_o    = code_q;

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_cur);
  // R7
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> hi_p);
  // R7
  rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_p) |-> (cnt_q == '0));
  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $past(period_end));
endmodule

// File: rtl/clk_ratio_div.sv
`timescale 1ns/1ps
module clk_ratio_div
  import clkdiv_pkg::*;
(
  input  logic              clk_cpu_i,
  input  logic              por_n_i,
  input  logic [CODE_W-1:0] strap_i,
  input  logic [CODE_W-1:0] sw_code_i,
  input  logic              sw_sel_i,
  output logic              div_clk_o,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] strap_rb_o
);
  fcode_t strap_q;
  fcode_t req_code;

  strap_latch #(.W(CODE_W)) u_latch (
    .clk(clk_cpu_i), .rst_n(por_n_i), .strap_i(strap_i), .strap_q(strap_q)
  );

  code_source #(.W(CODE_W)) u_src (
    .sel_sw(sw_sel_i), .strap_q(strap_q), .sw_code(sw_code_i),
    .req_code(req_code), .strap_rb(strap_rb_o)
  );

  ratio_divider u_div (
    .clk(clk_cpu_i), .rst_n(por_n_i), .req_code(req_code),
    .code_o(code_o), .div_clk_o(div_clk_o)
  );
endmodule

// File: tb/test_clk_ratio_div.sv
`timescale 1ns/1ps
module test_clk_ratio_div;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] strap = 4'b0011;
  logic [3:0] sw_code = 4'h0;
  logic       sw_sel = 1'b0;
  logic       div_clk;
  logic [3:0] code;
  logic [3:0] strap_rb;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  int m_cnt = 1, m_ratio = 2, m_code = 15, m_strap = 0;
  bit m_strap_valid = 0;
  int run_len = 0, hi_run = 0, last_len = 0, last_hi = 0;
  bit prev_out = 0;

  always #2.5 clk = ~clk;

  clk_ratio_div i_clk_ratio_div (
    .clk_cpu_i(clk), .por_n_i(rst_n), .strap_i(strap), .sw_code_i(sw_code),
    .sw_sel_i(sw_sel), .div_clk_o(div_clk), .code_o(code), .strap_rb_o(strap_rb)
  );

  function automatic int exp_ratio(input logic [3:0] c);
    if (c inside {4'hF, 4'hE, 4'hD, 4'h7, 4'h6, 4'h5}) return 2;
    if (c inside {4'h1, 4'h0}) return 4;
    return 3;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 1; m_ratio = 2; m_code = 15;
  endtask

  task automatic compare(input int h);
    bit eo;
    if (!rst_n) model_reset();
    eo = ((2 * m_cnt + h) < m_ratio);
    if (!rst_n) begin
      check(div_clk == 1'b0, "R9 out in reset", div_clk, 0);
      check(code == 4'hF, "R9 code in reset", code, 15);
    end else begin
      check(div_clk == eo, (m_ratio == 2) ? "R4/R7 out" : (m_ratio == 3) ? "R5/R7 out" : "R6/R7 out",
            div_clk, eo);
      check(code == 4'(m_code), "R8 code in effect", code, m_code);
    end
    if (m_strap_valid)
      check(strap_rb == ~4'(m_strap), "R2 readback", strap_rb, 4'(~m_strap));
    if (div_clk && !prev_out) begin
      last_len = run_len; last_hi = hi_run; run_len = 0; hi_run = 0;
    end
    run_len++;
    if (div_clk) hi_run++;
    prev_out = div_clk;
  endtask

  // monitor: update model at each rising edge, compare in both halves
  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        m_strap = strap; m_strap_valid = 1; model_reset();
      end else begin
        if (m_cnt == m_ratio - 1) begin
          m_code = sw_sel ? sw_code : 4'(m_strap);
          m_ratio = exp_ratio(4'(m_code));
          m_cnt = 0;
        end else m_cnt++;
      end
      #1 compare(0);
      @(negedge clk);
      #1 compare(1);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    cyc(4);
    check(div_clk == 1'b0 && code == 4'hF, "R9 reset state", code, 15);
    rst_n = 1'b1;
    cyc(1);
    strap = 4'b0001;          // must be ignored after release
    cyc(20);
    check(code == 4'b0011, "R1 strap held", code, 3);
    check(strap_rb == 4'b1100, "R2 inverted straps", strap_rb, 12);
    check(last_len == 6, "R3 strap code ratio", last_len, 6);

    sw_sel = 1'b1;
    for (int c = 0; c < 16; c++) begin
      int n;
      sw_code = 4'(c);
      cyc(14);
      n = exp_ratio(4'(c));
      check(code == 4'(c), "R3 software code", code, c);
      if (n == 2) check(last_len == 4, "R4 period", last_len, 4);
      else if (n == 3) check(last_len == 6, "R5 period", last_len, 6);
      else check(last_len == 8, "R6 period", last_len, 8);
      check(last_hi == n, "R7 high half-cycles", last_hi, n);
    end

    sw_code = 4'h0;
    cyc(10);
    do cyc(1); while (m_cnt != 0);
    sw_code = 4'hF;
    @(posedge clk); #1.5;
    check(code == 4'h0, "R8 mid-period change deferred", code, 0);
    @(posedge clk); #1.5;
    check(code == 4'h0, "R8 still deferred", code, 0);
    cyc(4);
    check(code == 4'hF, "R8 adopted at boundary", code, 15);

    rst_n = 1'b0; sw_sel = 1'b0; strap = 4'b1100;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    strap = 4'b1111;
    cyc(20);
    check(code == 4'b1100, "R1 recapture", code, 12);
    check(strap_rb == 4'b0011, "R2 recapture readback", strap_rb, 3);
    check(last_len == 6, "R5 strap /3", last_len, 6);
    finish_run();
  end
endmodule